// File: doc/BRIEF.md
# Sequential Two-Digit Seven-Segment Driver

This block presents a 6-bit number (0 to 63) on one seven-segment digit that has a decimal point. Because one digit cannot show two decimal places at once, it shows them in turn. First comes the tens digit with the point dark, then the ones digit with the point lit. The lit point tells a viewer which half of the number is on screen. A phase timer steps between the two halves. The input number is captured once per tens/ones pair, so both shown digits always come from the same sample. The binary sample is split into decimal digits by a shift-and-add-three converter and decoded to active-high segment patterns.

A 3-bit debug selector overrides the display. When it is nonzero, the eight output bits carry one byte of a wide debug bus instead of the digit, which lets internal state be inspected on the same pins. When the selector returns to zero, the normal display resumes.

Top module: `seq_digit_display`

## Requirements
- R1: While reset is high and the debug selector is 0, the output is 8'h3F, which is the pattern for digit 0 with bit 7 (the decimal point) low.
- R2: The input value is captured at the first clock edge after reset and then at the start of every tens phase. A change of the input during a tens/ones pair does not affect that pair.
- R3: The tens phase comes first after each capture, lasts exactly PHASE_CYCLES clocks, and drives output bit 7 low.
- R4: The ones phase follows each tens phase, lasts exactly PHASE_CYCLES clocks, and drives output bit 7 high.
- R5: The captured value v is split into a tens digit v/10 (range 0 to 6) and a ones digit v%10 (range 0 to 9).
- R6: Output bits 0 to 6 drive segments a to g, active high. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R7: When the debug selector m is nonzero, the output equals debug bus bits [8*(m-1)+7 : 8*(m-1)]. This applies in the same cycle and also during reset.
- R8: When the debug selector is 0, the output is the normal digit display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 6 | Number to display, 0 to 63 |
| debugMode | input | 3 | 0 selects the display; m>0 selects debug byte m-1 |
| debugBus | input | 56 | Internal debug signals, seven bytes |
| dispOut | output | 8 | Bits 0-6 are segments a-g; bit 7 is the decimal point (ones indicator) |

## Verification
The bench builds the block with PHASE_CYCLES set to 4. This shrinks the half-second phases to a few clocks, so that many full tens/ones pairs can be checked on every clock of each phase. Those pairs include the digit boundaries 9/10, 59/60 and the maximum 63. The input is changed in the middle of each pair, which checks that the display holds the captured sample. All seven debug byte slices are checked while reset holds the display still.

// File: rtl/seq_disp_pkg.sv
package seq_disp_pkg;
  localparam int VAL_W  = 6;
  localparam int DIG_W  = 4;
  localparam int OUT_W  = 8;
  localparam int SEG_W  = 7;

  typedef struct packed {
    logic latch;
    logic showOnes;
  } dispStrobes_t;
endpackage

// File: rtl/seq_disp_ctrl.sv
module seq_disp_ctrl
  import seq_disp_pkg::*;
#(
  parameter int PHASE_CYCLES = 62_500_000
) (
  input  logic         clk,
  input  logic         rst,
  output dispStrobes_t strobes
);
  localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic onesPhase;
  logic startUp;
  logic phaseEnd;

  assign phaseEnd = (phaseCnt == LAST) && !startUp;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt  <= '0;
      onesPhase <= 1'b0;
      startUp   <= 1'b1;
    end else if (startUp) begin
      startUp   <= 1'b0;
    end else if (phaseEnd) begin
      phaseCnt  <= '0;
      onesPhase <= ~onesPhase;
    end else begin
      phaseCnt  <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.latch    = startUp | (phaseEnd & onesPhase);
    strobes.showOnes = onesPhase;
  end

  // R3: a capture always opens a tens phase
  assert_latch_opens_tens_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.latch |=> !onesPhase);

  // R4: the phase flips only after a full count
  assert_phase_len_R4: assert property (@(posedge clk) disable iff (rst)
    (onesPhase != $past(onesPhase)) |-> ($past(phaseCnt) == LAST));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    phaseCnt <= LAST);
endmodule

// File: rtl/seq_disp_datapath.sv
module seq_disp_datapath
  import seq_disp_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter int DBG_W  = 8 * ((1 << MODE_W) - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  dispStrobes_t       strobes,
  input  logic [VAL_W-1:0]   value,
  input  logic [MODE_W-1:0]  debugMode,
  input  logic [DBG_W-1:0]   debugBus,
  output logic [OUT_W-1:0]   dispOut
);
  localparam int DD_W = VAL_W + 2 * DIG_W;

  logic [VAL_W-1:0] latched;
  logic [DIG_W-1:0] tensDig, onesDig, curDig;
  logic [SEG_W-1:0] segs;
  logic [OUT_W-1:0] normalOut;
  logic [OUT_W-1:0] dbgByte;

  always_ff @(posedge clk) begin
    if (rst)                latched <= '0;
    else if (strobes.latch) latched <= value;
  end

  // shift-and-add-three binary to decimal
  always_comb begin
    logic [DD_W-1:0] dd;
    logic [DIG_W-1:0] lo, hi;
    dd = {{(2*DIG_W){1'b0}}, latched};
    for (int i = 0; i < VAL_W; i++) begin
      lo = dd[VAL_W +: DIG_W];
      hi = dd[VAL_W + DIG_W +: DIG_W];
      if (lo >= 4'd5) lo = lo + 4'd3;
      if (hi >= 4'd5) hi = hi + 4'd3;
      dd = {hi, lo, dd[VAL_W-1:0]} << 1;
    end
    onesDig = dd[VAL_W +: DIG_W];
    tensDig = dd[VAL_W + DIG_W +: DIG_W];
  end

  assign curDig = strobes.showOnes ? onesDig : tensDig;

  always_comb begin
    case (curDig)
      4'd0:    segs = 7'h3F;
      4'd1:    segs = 7'h06;
      4'd2:    segs = 7'h5B;
      4'd3:    segs = 7'h4F;
      4'd4:    segs = 7'h66;
      4'd5:    segs = 7'h6D;
      4'd6:    segs = 7'h7D;
      4'd7:    segs = 7'h07;
      4'd8:    segs = 7'h7F;
      4'd9:    segs = 7'h6F;
      default: segs = 7'h00;
    endcase
  end

  assign normalOut = {strobes.showOnes, segs};

  always_comb begin
    dbgByte = '0;
    for (int m = 1; m < (1 << MODE_W); m++) begin
      if (int'(debugMode) == m) dbgByte = debugBus[8*(m-1) +: 8];
    end
  end

  assign dispOut = (debugMode == '0) ? normalOut : dbgByte;

  // R5: digit ranges and recombination
  assert_bcd_range_R5: assert property (@(posedge clk) disable iff (rst)
    (tensDig <= 4'd6) && (onesDig <= 4'd9));
  assert_bcd_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(tensDig) * 10 + int'(onesDig)) == int'(latched));
  // R2: sample held between captures
  assert_hold_sample_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.latch |=> $stable(latched));
endmodule

// File: rtl/seq_digit_display.sv
module seq_digit_display
  import seq_disp_pkg::*;
#(
  parameter int PHASE_CYCLES = 62_500_000,
  parameter int MODE_W       = 3,
  localparam int DBG_W       = 8 * ((1 << MODE_W) - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        value,
  input  logic [MODE_W-1:0] debugMode,
  input  logic [DBG_W-1:0]  debugBus,
  output logic [7:0]        dispOut
);
  dispStrobes_t strobes;

  seq_disp_ctrl #(.PHASE_CYCLES(PHASE_CYCLES)) ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  seq_disp_datapath #(.MODE_W(MODE_W), .DBG_W(DBG_W)) dpInst (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .value     (value),
    .debugMode (debugMode),
    .debugBus  (debugBus),
    .dispOut   (dispOut)
  );
endmodule

// File: tb/seq_digit_display_test.sv
module seq_digit_display_test;
  localparam int P = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [5:0]  value;
  logic [2:0]  debugMode;
  logic [55:0] debugBus;
  logic [7:0]  dispOut;

  seq_digit_display #(.PHASE_CYCLES(P), .MODE_W(3)) uut (
    .clk(clk), .rst(rst), .value(value),
    .debugMode(debugMode), .debugBus(debugBus), .dispOut(dispOut)
  );

  typedef struct {
    logic [7:0] exp;
    int         val;
    bit         ones;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  int pushed = 0, popped = 0;
  bit finished = 0;

  function automatic logic [6:0] segOf(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: push expected tens and ones item for a value (R5, R6)
  task automatic pushPair(int v);
    item_t t, o;
    t.val = v; t.ones = 0; t.exp = {1'b0, segOf(v / 10)};
    o.val = v; o.ones = 1; o.exp = {1'b1, segOf(v % 10)};
    q.push_back(t); q.push_back(o);
    pushed += 2;
  endtask

  initial begin
    int vals[8] = '{0, 9, 10, 37, 59, 60, 63, 45};
    rst = 1'b1; value = 6'd37; debugMode = 3'd0;
    for (int k = 0; k < 7; k++) debugBus[8*k +: 8] = 8'(k * 37 + 5);
    repeat (3) @(negedge clk);
    check(dispOut === 8'h3F, "R1 reset display", dispOut, 8'h3F);
    for (int m = 1; m < 8; m++) begin
      debugMode = 3'(m);
      #1;
      check(dispOut === debugBus[8*(m-1) +: 8], "R7 debug slice", dispOut, debugBus[8*(m-1) +: 8]);
    end
    debugMode = 3'd0;
    #1;
    check(dispOut === 8'h3F, "R8 display restored", dispOut, 8'h3F);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      value = 6'(vals[i]);
      pushPair(vals[i]);
      rst = 1'b0;
      repeat (P) @(negedge clk);
      value = 6'(vals[i] ^ 6'h2A);   // R2: mid-pair change must not show
      repeat (P) @(negedge clk);
    end
    wait (popped == pushed);
    repeat (2) @(negedge clk);
    finish();
  end

  // monitor: each phase must hold its expected byte for P clocks (R3, R4)
  initial begin
    wait (rst === 1'b0);
    @(posedge clk);
    forever begin
      item_t it;
      bit ok;
      logic [7:0] bad;
      wait (q.size() > 0);
      it = q.pop_front();
      ok = 1; bad = 8'h00;
      for (int c = 0; c < P; c++) begin
        @(negedge clk);
        if (dispOut !== it.exp && ok) begin ok = 0; bad = dispOut; end
      end
      check(ok, it.ones ? "R4 ones phase R2 R5 R6" : "R3 tens phase R2 R5 R6",
            ok ? it.exp : bad, it.exp);
      popped++;
    end
  end

  initial begin
    #(8 * 5000);
    checks++; errors++;
    $display("FAIL watchdog R3 actual=%h expected=%h", 8'h00, 8'h00);
    finish();
  end
endmodule